// File: doc/BRIEF.md
# Shared-Bus Second-Level Cache Controller

This block controls an optional external second-level cache. The cache's data SRAM shares the memory data lines with DRAM. When a request is accepted, the controller drives the cache index and compares the stored tag and valid bit with the upper address bits. On a hit it returns the SRAM data. During a hit the isolation switch stays off, so the heavy DRAM load is never seen on the shared lines. On a miss it turns the switch on and starts the DRAM access one cycle later than it would if the cache were absent. It then returns the DRAM line and writes that line into the indexed cache entry.

A plain `l2_present` input tells the controller whether the cache is fitted. When it is low, the controller skips the lookup and starts DRAM in the same cycle the request is taken. It never writes the SRAM in that case.

Requests and responses are valid/ready streams. Only one request is in flight at a time. `req_ready` is high only when the controller is idle, so the requester stalls until the previous response has been taken. A response stays on the outputs, unchanged, until `rsp_ready` takes it. While a response is held, no new request is accepted.

Top module: `l2_shared_bus_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, while `rsp_valid`, `switch_en`, `dram_start` and `sram_we` are all 0.
- R2: `req_ready` is 1 only when no request is in flight. It stays 0 from the accepting edge until the edge at which the response is taken with `rsp_ready`=1.
- R3: The address is split into an index, made of the low IDX_W bits and driven on `sram_idx`, and a tag, made of the remaining upper bits. The lookup hits only when `sram_tag_valid_i`=1 and `sram_tag_i` equals the tag.
- R4: On a hit, `rsp_valid` rises HIT_LAT cycles after the accepting edge (6 by default). At that point `rsp_hit`=1 and `rsp_data` equals `sram_data_i`.
- R5: `switch_en` stays 0 for the whole of a hit transaction, and `dram_start` is never raised during one.
- R6: On a miss with the cache present, `dram_start` is a one-cycle pulse that starts 1 cycle after the accepting edge. `switch_en` rises with it and falls when the response appears.
- R7: With `l2_present`=0 at acceptance, `dram_start` and `switch_en` rise at the accepting edge, which is one cycle earlier than on a miss with the cache present.
- R8: On the edge where `dram_ready`=1 during a DRAM access, the response is presented with `rsp_hit`=0 and `rsp_data`=`dram_data_i`.
- R9: On a miss with the cache present, that same edge writes the DRAM line, the tag and a set valid bit into the indexed entry. A later request to the same address then hits. An access with the cache absent writes nothing.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` and `rsp_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l2_present | input | 1 | Second-level cache fitted; sampled at acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | ADDR_W | Line address of the request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Returned line |
| rsp_hit | output | 1 | Response came from the second-level cache |
| sram_idx | output | IDX_W | Index to tag and data SRAM |
| sram_tag_valid_i | input | 1 | Valid bit of the indexed tag entry |
| sram_tag_i | input | ADDR_W-IDX_W | Stored tag of the indexed entry |
| sram_data_i | input | DATA_W | SRAM data on the shared lines |
| sram_we | output | 1 | Fill write of data, tag and valid at `sram_idx` |
| sram_wtag | output | ADDR_W-IDX_W | Tag written on fill |
| sram_wdata | output | DATA_W | Line written on fill |
| dram_start | output | 1 | One-cycle DRAM access start |
| dram_addr | output | ADDR_W | DRAM access address |
| dram_ready | input | 1 | DRAM data valid this cycle |
| dram_data_i | input | DATA_W | DRAM data, seen through the isolation switch |
| switch_en | output | 1 | Isolation switch on: DRAM joins the shared lines |

## Verification
The bench builds the controller with ADDR_W=6, IDX_W=3, DATA_W=64 and HIT_LAT=6, against an 8-entry tag/data stub and a fixed-latency DRAM stub. This makes the whole 64-address space small enough to sweep completely, and every index sees cold misses, conflict misses from tags that evict one another, and hits after a fill. Each address is also swept with the cache absent, and a sweep with the cache present then follows, which shows that the absent accesses left the stored entries unchanged. Response latency, the `dram_start` cycle and the switch timing are measured for every request, and responses are held back for zero to two cycles to exercise back-pressure.

// File: rtl/l2c_pkg.sv
package l2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_SRAM,
    ST_DRAM,
    ST_RESP
  } l2c_state_e;
endpackage

// File: rtl/l2c_tag_cmp.sv
module l2c_tag_cmp #(
  parameter int TAG_W = 10
) (
  input  logic             entry_valid,
  input  logic [TAG_W-1:0] entry_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit
);
  always_comb hit = entry_valid && (entry_tag == req_tag);
endmodule

// File: rtl/l2c_seq.sv
module l2c_seq
  import l2c_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int HIT_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l2_present,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              tag_hit,
  input  logic              dram_ready,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dram_start,
  output logic              switch_en,
  output logic              sram_we,
  output logic              load,
  output logic              load_hit
);
  localparam int CNT_W = $clog2(HIT_LAT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HIT_LAT - 1);

  l2c_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             present_q;
  logic             sram_done;
  logic             dram_done;

  always_comb begin
    req_ready = (state == ST_IDLE);
    sram_done = (state == ST_SRAM) && (cnt == LAST_CNT);
    dram_done = (state == ST_DRAM) && dram_ready;
    load      = sram_done || dram_done;
    load_hit  = sram_done;
    sram_we   = dram_done && present_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      addr_q     <= '0;
      present_q  <= 1'b0;
      dram_start <= 1'b0;
      switch_en  <= 1'b0;
    end else begin
      dram_start <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q    <= req_addr;
          present_q <= l2_present;
          cnt       <= '0;
          if (l2_present) begin
            state <= ST_TAG;
          end else begin
            state      <= ST_DRAM;
            dram_start <= 1'b1;
            switch_en  <= 1'b1;
          end
        end
        ST_TAG: begin
          cnt <= cnt + 1'b1;
          if (tag_hit) begin
            state <= ST_SRAM;
          end else begin
            state      <= ST_DRAM;
            dram_start <= 1'b1;
            switch_en  <= 1'b1;
          end
        end
        ST_SRAM: begin
          cnt <= cnt + 1'b1;
          if (sram_done) state <= ST_RESP;
        end
        ST_DRAM: if (dram_ready) begin
          switch_en <= 1'b0;
          state     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DRAM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dram_start |=> !dram_start); // R6
  AST_HIT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SRAM) |-> (!switch_en && !dram_start)); // R5
  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (switch_en && present_q)); // R9
  AST_ABSENT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !l2_present) |=> (dram_start && switch_en)); // R7
endmodule

// File: rtl/l2c_resp.sv
module l2c_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_hit,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
      rsp_hit   <= load_hit;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
endmodule

// File: rtl/l2_shared_bus_ctrl.sv
module l2_shared_bus_ctrl #(
  parameter int ADDR_W  = 20,
  parameter int IDX_W   = 10,
  parameter int DATA_W  = 128,
  parameter int HIT_LAT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    l2_present,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_hit,
  output logic [IDX_W-1:0]        sram_idx,
  input  logic                    sram_tag_valid_i,
  input  logic [ADDR_W-IDX_W-1:0] sram_tag_i,
  input  logic [DATA_W-1:0]       sram_data_i,
  output logic                    sram_we,
  output logic [ADDR_W-IDX_W-1:0] sram_wtag,
  output logic [DATA_W-1:0]       sram_wdata,
  output logic                    dram_start,
  output logic [ADDR_W-1:0]       dram_addr,
  input  logic                    dram_ready,
  input  logic [DATA_W-1:0]       dram_data_i,
  output logic                    switch_en
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  req_tag;
  logic [DATA_W-1:0] bus_data;
  logic              tag_hit;
  logic              load;
  logic              load_hit;

  always_comb begin
    req_tag    = addr_q[ADDR_W-1:IDX_W];
    sram_idx   = addr_q[IDX_W-1:0];
    sram_wtag  = req_tag;
    dram_addr  = addr_q;
    bus_data   = switch_en ? dram_data_i : sram_data_i;
    sram_wdata = bus_data;
  end

  l2c_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .entry_valid (sram_tag_valid_i),
    .entry_tag   (sram_tag_i),
    .req_tag     (req_tag),
    .hit         (tag_hit)
  );

  l2c_seq #(.ADDR_W(ADDR_W), .HIT_LAT(HIT_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .l2_present (l2_present),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .tag_hit    (tag_hit),
    .dram_ready (dram_ready),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .addr_q     (addr_q),
    .dram_start (dram_start),
    .switch_en  (switch_en),
    .sram_we    (sram_we),
    .load       (load),
    .load_hit   (load_hit)
  );

  l2c_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_hit  (load_hit),
    .load_data (bus_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_hit   (rsp_hit)
  );

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R2
  AST_HIT_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !switch_en); // R5
endmodule

// File: tb/l2_shared_bus_ctrl_bench.sv
module l2_shared_bus_ctrl_bench;
  localparam int AW = 6, IW = 3, DW = 64, HL = 6, DLAT = 5;
  localparam int TW = AW - IW;
  localparam int NENT = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic l2_present = 1, req_valid = 0, rsp_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, sram_we, dram_start, switch_en;
  logic [DW-1:0] rsp_data, sram_wdata;
  logic [IW-1:0] sram_idx;
  logic [TW-1:0] sram_wtag;
  logic [AW-1:0] dram_addr;
  logic sram_tag_valid_i, dram_ready;
  logic [TW-1:0] sram_tag_i;
  logic [DW-1:0] sram_data_i, dram_data_i;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  l2_shared_bus_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .HIT_LAT(HL)) u_l2_shared_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .l2_present(l2_present),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .sram_idx(sram_idx), .sram_tag_valid_i(sram_tag_valid_i), .sram_tag_i(sram_tag_i),
    .sram_data_i(sram_data_i), .sram_we(sram_we), .sram_wtag(sram_wtag), .sram_wdata(sram_wdata),
    .dram_start(dram_start), .dram_addr(dram_addr), .dram_ready(dram_ready),
    .dram_data_i(dram_data_i), .switch_en(switch_en)
  );

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    return 64'h0123_4567_89AB_0000 + 64'(a) * 64'h0001_0000_0001;
  endfunction

  // SRAM stub
  logic          s_vld [NENT];
  logic [TW-1:0] s_tag [NENT];
  logic [DW-1:0] s_dat [NENT];
  assign sram_tag_valid_i = s_vld[sram_idx];
  assign sram_tag_i       = s_tag[sram_idx];
  assign sram_data_i      = s_dat[sram_idx];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        s_vld[i] <= 1'b0; s_tag[i] <= '0; s_dat[i] <= '0;
      end
    end else if (sram_we) begin
      s_vld[sram_idx] <= 1'b1;
      s_tag[sram_idx] <= sram_wtag;
      s_dat[sram_idx] <= sram_wdata;
    end
  end

  // DRAM stub: fixed latency after the start pulse
  int dcnt = 0;
  assign dram_ready  = (dcnt == DLAT);
  assign dram_data_i = line_of(dram_addr);
  always @(posedge clk) begin
    if (!rst_n) dcnt <= 0;
    else if (dram_start) dcnt <= 1;
    else if (dcnt == DLAT) dcnt <= 0;
    else if (dcnt != 0) dcnt <= dcnt + 1;
  end

  // bench's own cache model
  bit       m_vld [NENT];
  int       m_tag [NENT];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input int a, input bit present, input int hold);
    int  idx = a % NENT;
    int  tg  = a / NENT;
    bit  exp_hit = present && m_vld[idx] && (m_tag[idx] == tg);
    int  exp_ds  = exp_hit ? -1 : (present ? 1 : 0);
    int  exp_lat = exp_hit ? HL : exp_ds + DLAT + 1;
    int  k = 0, first_ds = -1;
    bit  sw_bad = 0, rdy_bad = 0;
    logic [DW-1:0] held;
    @(negedge clk);
    l2_present = present; req_addr = AW'(a); req_valid = 1;
    chk(req_ready == 1, "R2", "idle ready", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (k < 100) begin
      if (rsp_valid) break;
      if (req_ready) rdy_bad = 1;
      if (dram_start) begin
        if (first_ds < 0) first_ds = k; else sw_bad = 1;
      end
      if (exp_hit && switch_en) sw_bad = 1;
      if (!exp_hit && first_ds >= 0 && !switch_en) sw_bad = 1;
      @(negedge clk);
      k++;
    end
    chk(!rdy_bad, "R2", "ready low in flight", rdy_bad, 0);
    chk(k == exp_lat, exp_hit ? "R4" : "R8", "latency", k, exp_lat);
    chk(first_ds == exp_ds, present ? "R6" : "R7", "dram_start cycle", first_ds, exp_ds);
    chk(!sw_bad, exp_hit ? "R5" : "R6", "switch timing", sw_bad, 0);
    chk(rsp_hit == exp_hit, exp_hit ? "R3" : "R8", "hit flag", rsp_hit, exp_hit);
    chk(rsp_data == line_of(AW'(a)), exp_hit ? "R4" : "R8", "data", rsp_data, line_of(AW'(a)));
    chk(switch_en == 0, "R6", "switch off at response", switch_en, 0);
    held = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held, "R10", "held response", rsp_data, held);
      chk(req_ready == 0, "R2", "no accept while held", req_ready, 0);
    end
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R2", "idle after take", {rsp_valid, req_ready}, 2'b01);
    if (present && !exp_hit) begin
      m_vld[idx] = 1; m_tag[idx] = tg; // R9 fill
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(req_ready && !rsp_valid && !switch_en && !dram_start && !sram_we,
        "R1", "reset outputs", {req_ready, rsp_valid, switch_en, dram_start, sram_we}, 5'b10000);
    // R3 R4 R6 R9: miss, hit after fill, conflict eviction
    for (int a = 0; a < (1 << AW); a++) begin
      do_req(a, 1, a % 3);
      do_req(a, 1, 0);
      do_req(a ^ NENT, 1, 1);
      do_req(a, 1, 0);
    end
    // R7 R9: absent accesses go straight to DRAM and leave entries untouched
    for (int a = 0; a < (1 << AW); a++) do_req(a, 0, a % 2);
    for (int a = 0; a < (1 << AW); a++) do_req(a, 1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule